// File: doc/BRIEF.md
# Three-Phase Bridge Gate Sequencer

This block drives the six gate-enable bits of a three-phase half-bridge power stage from a clock-synchronous controller. Each phase has two command inputs. The high-side command is active-low. The low-side command is active-high and, in normal mode, takes precedence over the high-side command in the same phase. Any output turns off at the first clock edge after its request goes away. Turning an output on waits a programmable number of clock edges, so that the opposite switch of the phase has time to stop conducting.

After reset, and again whenever disable or undervoltage is released, the block runs a bootstrap refresh interval. During this interval all low-side outputs are on and all high-side outputs are off. Normal command handling starts when the interval ends. The dead-time count and the refresh length are plain cycle-count inputs. The block captures them only while it is outside normal operation. A bypass mode removes both the interlock and the turn-on delay. It is selected by the bypass pin or by a dead-time count of zero.

All pins are plain control levels: there is no data stream and no handshake. Each output is a register whose value depends only on the inputs sampled at the preceding edges.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While `dis_i` is 1 at a clock edge, all six outputs are 0 after that edge, whatever the other inputs are.
- R2: While `uv_i` is 1 at a clock edge, all six outputs are 0 after that edge, whatever the command inputs are.
- R3: The high-side command of a phase is active-low: `hi_cmd_n_i[p]`=0 requests `hs_gate_o[p]` on, and 1 requests it off.
- R4: In normal mode, `lo_cmd_i[p]`=1 requests `ls_gate_o[p]` on and forces `hs_gate_o[p]` off, whatever `hi_cmd_n_i[p]` is. In this mode the two outputs of a phase are never both 1 after an edge at which normal mode was in effect.
- R5: In normal mode, when `lo_cmd_i[p]`=0 and `hi_cmd_n_i[p]`=1, both outputs of phase p are off. When `lo_cmd_i[p]`=0 and `hi_cmd_n_i[p]`=0, the high side is on and the low side is off.
- R6: Bypass mode is in effect when `bypass_i`=1 or when the captured dead-time count is 0. In this mode each output follows its own request at the next edge, with no interlock, so `lo_cmd_i[p]`=1 together with `hi_cmd_n_i[p]`=0 turns both outputs of phase p on.
- R7: An output whose request is absent at a clock edge is 0 after that edge.
- R8: In normal mode with captured dead-time count D≥1, an off output turns on after the D-th consecutive edge at which its request is present. The same D applies to all six outputs.
- R9: If the request drops before the D-th edge, the pending turn-on is cancelled. A later request waits a full D edges again.
- R10: After reset, the first edge with `rst_n`, `dis_i` and `uv_i` inactive starts the refresh. For L = max(`refresh_cycles_i`, RFSH_MIN) cycles, all low-side outputs are 1 and all high-side outputs are 0. The output after the next edge follows normal command handling.
- R11: Releasing `dis_i` or `uv_i` restarts the refresh interval of R10 from the beginning.
- R12: `dead_cycles_i` and `refresh_cycles_i` are captured only while the block is not in normal operation. Changing them during normal operation does not alter the turn-on delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dis_i | input | 1 | Global disable; forces all outputs off |
| uv_i | input | 1 | Undervoltage flag; forces all outputs off |
| bypass_i | input | 1 | Removes the interlock and the turn-on delay |
| hi_cmd_n_i | input | NUM_PH | High-side commands, active low, one bit per phase |
| lo_cmd_i | input | NUM_PH | Low-side commands, active high, one bit per phase |
| dead_cycles_i | input | CNT_W | Turn-on delay in clock edges |
| refresh_cycles_i | input | CNT_W | Requested refresh length in cycles, floored at RFSH_MIN |
| hs_gate_o | output | NUM_PH | High-side gate enables |
| ls_gate_o | output | NUM_PH | Low-side gate enables |

## Verification
A stuck or mis-sequenced start-up state shows at the ports at once. The low-side outputs stay all-ones past the end of the interval, or they drop before it ends, and the scoreboard checks the final refresh cycle and the cycle after it. A turn-on counter that is not cleared, or that uses the wrong limit, makes a gate rise one or more cycles early or late. The checks bracket every turn-on at edge D-1 and edge D. A broken interlock or an ignored disable shows within one edge as a forbidden output pair.

// File: rtl/bgc_pkg.sv
`timescale 1ns/1ps
package bgc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REFRESH = 2'd1,
    ST_RUN     = 2'd2
  } bgc_state_e;
endpackage

// File: rtl/bgc_startup.sv
`timescale 1ns/1ps
module bgc_startup
  import bgc_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int RFSH_MIN = 375
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_i,
  input  logic [CNT_W-1:0] dead_cfg_i,
  input  logic [CNT_W-1:0] rfsh_cfg_i,
  output logic             refresh_o,
  output logic [CNT_W-1:0] dead_o
);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(RFSH_MIN);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  bgc_state_e       state_q;
  logic [CNT_W-1:0] rcnt_q;
  logic [CNT_W-1:0] rlen_q;
  logic [CNT_W-1:0] dead_q;
  logic [CNT_W-1:0] eff_len;

  // a requested length below the floor is raised to the floor
  assign eff_len = (rfsh_cfg_i < MIN_LEN) ? MIN_LEN : rfsh_cfg_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rcnt_q  <= '0;
      rlen_q  <= MIN_LEN;
      dead_q  <= '0;
    end else if (kill_i) begin
      state_q <= ST_IDLE;
      rcnt_q  <= '0;
      rlen_q  <= eff_len;
      dead_q  <= dead_cfg_i;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_REFRESH;
          rcnt_q  <= ONE;
          rlen_q  <= eff_len;
          dead_q  <= dead_cfg_i;
        end
        ST_REFRESH: begin
          dead_q <= dead_cfg_i;
          if (rcnt_q == rlen_q - ONE) begin
            state_q <= ST_RUN;
            rcnt_q  <= '0;
          end else begin
            rcnt_q <= rcnt_q + ONE;
          end
        end
        default: begin
          state_q <= ST_RUN;
        end
      endcase
    end
  end

  assign refresh_o = (state_q != ST_RUN);
  assign dead_o    = dead_q;

  assert_refresh_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REFRESH) |-> (rcnt_q < rlen_q));

  assert_kill_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (state_q == ST_IDLE) && (rcnt_q == '0));

  assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !kill_i) |=> $stable(dead_q));
endmodule

// File: rtl/bgc_resolve.sv
`timescale 1ns/1ps
module bgc_resolve #(
  parameter int NUM_PH = 3
) (
  input  logic [NUM_PH-1:0] hi_cmd_n_i,
  input  logic [NUM_PH-1:0] lo_cmd_i,
  input  logic              bypass_i,
  output logic [NUM_PH-1:0] hs_req_o,
  output logic [NUM_PH-1:0] ls_req_o
);
  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    always_comb begin
      ls_req_o[p] = lo_cmd_i[p];
      if (bypass_i) hs_req_o[p] = !hi_cmd_n_i[p];
      else          hs_req_o[p] = !hi_cmd_n_i[p] && !lo_cmd_i[p];
    end
  end
endmodule

// File: rtl/bgc_gate_timer.sv
`timescale 1ns/1ps
module bgc_gate_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_i,
  input  logic             force_en_i,
  input  logic             force_val_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic             req_i,
  output logic             gate_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             gate_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (kill_i) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (force_en_i) begin
      gate_q <= force_val_i;
      cnt_q  <= '0;
    end else if (!req_i) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (gate_q) begin
      cnt_q <= '0;
    end else if (bypass_i || cnt_q == dead_i - ONE) begin
      gate_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign gate_o = gate_q;

  assert_fast_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_i && !force_en_i && !req_i) |=> !gate_o);

  assert_no_early_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_i && !force_en_i && !bypass_i && req_i && !gate_o &&
     dead_i != '0 && cnt_q < dead_i - ONE) |=> !gate_o);

  assert_cancel_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_i) |=> (cnt_q == '0));
endmodule

// File: rtl/bridge_gate_ctrl.sv
`timescale 1ns/1ps
module bridge_gate_ctrl #(
  parameter int NUM_PH   = 3,
  parameter int CNT_W    = 12,
  parameter int RFSH_MIN = 375
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dis_i,
  input  logic              uv_i,
  input  logic              bypass_i,
  input  logic [NUM_PH-1:0] hi_cmd_n_i,
  input  logic [NUM_PH-1:0] lo_cmd_i,
  input  logic [CNT_W-1:0]  dead_cycles_i,
  input  logic [CNT_W-1:0]  refresh_cycles_i,
  output logic [NUM_PH-1:0] hs_gate_o,
  output logic [NUM_PH-1:0] ls_gate_o
);
  logic              kill;
  logic              refresh;
  logic              byp_eff;
  logic [CNT_W-1:0]  dead_q;
  logic [NUM_PH-1:0] hs_req;
  logic [NUM_PH-1:0] ls_req;

  assign kill    = dis_i | uv_i;
  assign byp_eff = bypass_i | (dead_q == '0);

  bgc_startup #(.CNT_W(CNT_W), .RFSH_MIN(RFSH_MIN)) u_startup (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill_i     (kill),
    .dead_cfg_i (dead_cycles_i),
    .rfsh_cfg_i (refresh_cycles_i),
    .refresh_o  (refresh),
    .dead_o     (dead_q)
  );

  bgc_resolve #(.NUM_PH(NUM_PH)) u_resolve (
    .hi_cmd_n_i (hi_cmd_n_i),
    .lo_cmd_i   (lo_cmd_i),
    .bypass_i   (byp_eff),
    .hs_req_o   (hs_req),
    .ls_req_o   (ls_req)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    bgc_gate_timer #(.CNT_W(CNT_W)) u_hs (
      .clk         (clk),
      .rst_n       (rst_n),
      .kill_i      (kill),
      .force_en_i  (refresh),
      .force_val_i (1'b0),
      .bypass_i    (byp_eff),
      .dead_i      (dead_q),
      .req_i       (hs_req[p]),
      .gate_o      (hs_gate_o[p])
    );
    bgc_gate_timer #(.CNT_W(CNT_W)) u_ls (
      .clk         (clk),
      .rst_n       (rst_n),
      .kill_i      (kill),
      .force_en_i  (refresh),
      .force_val_i (1'b1),
      .bypass_i    (byp_eff),
      .dead_i      (dead_q),
      .req_i       (ls_req[p]),
      .gate_o      (ls_gate_o[p])
    );
  end

  // bypass status as sampled at the last edge, for the interlock check
  logic byp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b1;
    else        byp_q <= byp_eff;
  end

  assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |=> (hs_gate_o == '0) && (ls_gate_o == '0));

  assert_undervolt_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (hs_gate_o == '0) && (ls_gate_o == '0));

  assert_interlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_q |-> ((hs_gate_o & ls_gate_o) == '0));

  assert_refresh_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !kill) |=> (hs_gate_o == '0) && (ls_gate_o == '1));
endmodule

// File: tb/test_bridge_gate_ctrl.sv
`timescale 1ns/1ps
module test_bridge_gate_ctrl;
  localparam int NP = 3;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dis_i = 1'b0, uv_i = 1'b0, bypass_i = 1'b0;
  logic [NP-1:0] hi_cmd_n_i = '1, lo_cmd_i = '0;
  logic [CW-1:0] dead_cycles_i = 12'd4, refresh_cycles_i = 12'd10;
  logic [NP-1:0] hs_gate_o, ls_gate_o;

  bridge_gate_ctrl i_bridge_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .dis_i(dis_i), .uv_i(uv_i), .bypass_i(bypass_i),
    .hi_cmd_n_i(hi_cmd_n_i), .lo_cmd_i(lo_cmd_i),
    .dead_cycles_i(dead_cycles_i), .refresh_cycles_i(refresh_cycles_i),
    .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    int            stamp;
    logic [NP-1:0] hs;
    logic [NP-1:0] ls;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;

  // driver side: queue an expected output pair d cycles from now
  task automatic expect_out(int d, logic [NP-1:0] h, logic [NP-1:0] l, string tag);
    exp_t e;
    int   pos;
    e.stamp = cyc + d; e.hs = h; e.ls = l; e.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].stamp > e.stamp) begin pos = i; break; end
    end
    q.insert(pos, e);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: sample well after the edge and pop matching items
  always begin
    @(posedge clk);
    cyc++;
    #3;
    while (q.size() > 0 && q[0].stamp <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.stamp != cyc || hs_gate_o !== e.hs || ls_gate_o !== e.ls) begin
        failures++;
        $display("FAIL %s cyc=%0d hs=%b ls=%b expected hs=%b ls=%b",
                 e.tag, cyc, hs_gate_o, ls_gate_o, e.hs, e.ls);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    hi_cmd_n_i = 3'b000;
    step(3);
    expect_out(0, 3'b000, 3'b000, "R10 reset state");
    step(1);
    // release reset; refresh floored to 375 cycles
    rst_n = 1'b1;
    expect_out(1,   3'b000, 3'b111, "R10 refresh start");
    expect_out(200, 3'b000, 3'b111, "R10 hs held off despite R3 request");
    expect_out(375, 3'b000, 3'b111, "R10 refresh last cycle");
    expect_out(376, 3'b000, 3'b000, "R10 refresh end");
    expect_out(378, 3'b000, 3'b000, "R8 before D edges");
    expect_out(379, 3'b111, 3'b000, "R3 active-low high side on");
    step(382);

    hi_cmd_n_i = 3'b010;
    expect_out(1, 3'b101, 3'b000, "R7 turn-off next edge");
    step(2);

    lo_cmd_i = 3'b001;
    expect_out(1, 3'b100, 3'b000, "R4 low command forces high off");
    expect_out(3, 3'b100, 3'b000, "R8 low side waits");
    expect_out(4, 3'b100, 3'b001, "R4 low side on after D");
    step(6);

    hi_cmd_n_i = 3'b111; lo_cmd_i = 3'b000;
    expect_out(1, 3'b000, 3'b000, "R5 both off");
    step(3);

    hi_cmd_n_i = 3'b110;
    step(2);
    hi_cmd_n_i = 3'b111;
    expect_out(1, 3'b000, 3'b000, "R9 cancelled");
    expect_out(4, 3'b000, 3'b000, "R9 stays off");
    step(6);
    hi_cmd_n_i = 3'b110;
    expect_out(3, 3'b000, 3'b000, "R9 full delay again");
    expect_out(4, 3'b001, 3'b000, "R5 high on low off");
    step(6);

    dis_i = 1'b1; lo_cmd_i = 3'b111; hi_cmd_n_i = 3'b000;
    expect_out(1, 3'b000, 3'b000, "R1 disable");
    expect_out(4, 3'b000, 3'b000, "R1 disable held");
    step(5);
    dis_i = 1'b0; lo_cmd_i = 3'b000; hi_cmd_n_i = 3'b111;
    expect_out(1,   3'b000, 3'b111, "R11 refresh restarts");
    expect_out(375, 3'b000, 3'b111, "R11 refresh last cycle");
    expect_out(376, 3'b000, 3'b000, "R11 refresh end");
    step(380);

    dead_cycles_i = 12'd8;
    hi_cmd_n_i = 3'b110;
    expect_out(3, 3'b000, 3'b000, "R12 old delay kept");
    expect_out(4, 3'b001, 3'b000, "R12 old delay kept");
    step(6);
    hi_cmd_n_i = 3'b111;
    step(2);

    uv_i = 1'b1; hi_cmd_n_i = 3'b000;
    expect_out(1, 3'b000, 3'b000, "R2 undervoltage");
    expect_out(4, 3'b000, 3'b000, "R2 undervoltage held");
    step(5);
    refresh_cycles_i = 12'd500;
    uv_i = 1'b0; hi_cmd_n_i = 3'b111;
    expect_out(1,   3'b000, 3'b111, "R10 lengthened refresh");
    expect_out(500, 3'b000, 3'b111, "R10 lengthened last cycle");
    expect_out(501, 3'b000, 3'b000, "R10 lengthened end");
    step(503);

    hi_cmd_n_i = 3'b101;
    expect_out(7, 3'b000, 3'b000, "R8 new delay not yet");
    expect_out(8, 3'b010, 3'b000, "R8 new delay reached");
    step(10);
    hi_cmd_n_i = 3'b111;
    step(2);

    bypass_i = 1'b1; hi_cmd_n_i = 3'b110; lo_cmd_i = 3'b001;
    expect_out(1, 3'b001, 3'b001, "R6 bypass both on");
    step(3);
    bypass_i = 1'b0;
    expect_out(1, 3'b000, 3'b001, "R4 interlock returns");
    step(3);

    dis_i = 1'b1; dead_cycles_i = 12'd0; refresh_cycles_i = 12'd0;
    hi_cmd_n_i = 3'b111; lo_cmd_i = 3'b000;
    step(2);
    dis_i = 1'b0;
    expect_out(1, 3'b000, 3'b111, "R11 refresh after disable");
    step(377);
    hi_cmd_n_i = 3'b110; lo_cmd_i = 3'b001;
    expect_out(1, 3'b001, 3'b001, "R6 zero dead count bypass");
    step(4);

    if (q.size() != 0) begin
      failures++;
      $display("FAIL pending expectations left: %0d expected 0", q.size());
    end
    finish_run();
  end
endmodule